// File: doc/BRIEF.md
# Windowed Inbound Address Translator

This block rewrites an address that arrives from a serial link into an address in the local memory map. Four programmable windows tile the remote address space with no gaps, starting at remote address zero. The first window starts at zero, and each following window starts where the one before it ends. Each window has a size and an offset. The block finds the first window that contains the incoming address. It then subtracts the start of that window, which is the sum of the sizes of all earlier windows, and adds the window's offset. An address beyond the last window gives zero and a cleared hit flag.

Software or a link controller loads the four size/offset pairs through a simple write port. Addresses are then presented one per cycle with a valid strobe. The translated address, a hit flag and a valid flag appear one cycle later.

Top module: `inbound_xlate`

## Requirements
- R1: An address below size 1 gives a hit and the result address + offset 1.
- R2: Otherwise, an address below size 1 + size 2 gives a hit and the result address + offset 2 − size 1.
- R3: Otherwise, an address below size 1 + size 2 + size 3 gives a hit and the result address + offset 3 − size 1 − size 2.
- R4: Otherwise, an address below the sum of all four sizes gives a hit and the result address + offset 4 − size 1 − size 2 − size 3.
- R5: An address at or above the sum of all four sizes gives result 0 with hit low. Whenever hit is low, the result is 0.
- R6: The windows are tested in order from 1 to 4, and the lowest-numbered matching window decides the result. A window of size zero never matches.
- R7: Addresses, sizes and offsets are 32 bits wide. Every sum and difference, including the window bounds, wraps modulo 2^32.
- R8: The output valid is high exactly one cycle after a cycle in which the input valid was high. The result for that address is on the outputs in the same cycle.
- R9: In a cycle with input valid low, the result address and hit keep their previous values.
- R10: Configuration write encoding: cfgSel 0..3 selects window 1..4, and cfgIsOffset=1 writes the offset while cfgIsOffset=0 writes the size. A write is seen by addresses presented in later cycles. An address presented in the same cycle as the write still uses the old value. A write never changes a result that is already registered.
- R11: After reset, all sizes and offsets are zero, the outputs are zero, and every address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Window index, 0..3 for window 1..4 |
| cfgIsOffset | input | 1 | 1 writes the offset, 0 writes the size |
| cfgData | input | 32 | Value to write |
| inValid | input | 1 | Incoming address is valid |
| inAddr | input | 32 | Remote address to translate |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outHit | output | 1 | A window matched |
| outAddr | output | 32 | Translated local address, or 0 on a miss |

## Verification
The assertions assume that the write port and the address port are driven only with settled values between clock edges. They also assume that cfgSel always names one of the four windows. The bench drives every input at the falling edge and uses only in-range window indexes. It sweeps every address across a few small window layouts, plus layouts whose offsets and bounds wrap past 2^32. It compares each result against an arithmetic model of the cumulative windows.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch a new translation result
    logic wrSize;    // load the selected window size
    logic wrOffset;  // load the selected window offset
  } xlStrobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic      cfgIsOffset,
  input  logic      inValid,
  output xlStrobe_t strb,
  output logic      outValid
);

  always_comb begin
    strb.capture  = inValid;
    strb.wrSize   = cfgWe & ~cfgIsOffset;
    strb.wrOffset = cfgWe & cfgIsOffset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8: result valid follows the input strobe by exactly one cycle
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 4,
  localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strb,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outHit
);

  logic [ADDR_W-1:0] sizeQ  [NUM_WIN];
  logic [ADDR_W-1:0] offQ   [NUM_WIN];
  logic [ADDR_W-1:0] winBase[NUM_WIN];
  logic [ADDR_W-1:0] winEnd [NUM_WIN];
  logic [ADDR_W-1:0] cand   [NUM_WIN];
  logic [NUM_WIN-1:0] inWin;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    // per-window register pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sizeQ[k] <= '0;
        offQ[k]  <= '0;
      end else if (cfgSel == SEL_W'(k)) begin
        if (strb.wrSize)   sizeQ[k] <= cfgData;
        if (strb.wrOffset) offQ[k]  <= cfgData;
      end
    end

    // cumulative bounds: window k starts where window k-1 ends
    if (k == 0) begin : g_first
      assign winBase[k] = '0;
    end else begin : g_next
      assign winBase[k] = winEnd[k-1];
    end
    assign winEnd[k] = winBase[k] + sizeQ[k];
    assign inWin[k]  = inAddr < winEnd[k];
    assign cand[k]   = inAddr + offQ[k] - winBase[k];
  end

  // priority pick: lowest window index wins
  logic [ADDR_W-1:0] nextAddr;
  logic              nextHit;
  always_comb begin
    nextAddr = '0;
    nextHit  = 1'b0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (!nextHit && inWin[k]) begin
        nextHit  = 1'b1;
        nextAddr = cand[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr <= '0;
      outHit  <= 1'b0;
    end else if (strb.capture) begin
      outAddr <= nextAddr;
      outHit  <= nextHit;
    end
  end

  // R1: address under the first size lands in window 1
  a_r1_first_window: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (inAddr < sizeQ[0])) |=>
      (outHit && outAddr == $past(inAddr + offQ[0])));
  // R5: a miss always reports zero
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outAddr == '0));
  // R9: no new address, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(outAddr) && $stable(outHit)));

endmodule

// File: rtl/inbound_xlate.sv
module inbound_xlate
  import xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 4,
  localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              cfgIsOffset,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  output logic              outHit,
  output logic [ADDR_W-1:0] outAddr
);

  xlStrobe_t strb;

  xlate_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgIsOffset (cfgIsOffset),
    .inValid     (inValid),
    .strb        (strb),
    .outValid    (outValid)
  );

  xlate_dp #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .inAddr  (inAddr),
    .outAddr (outAddr),
    .outHit  (outHit)
  );

endmodule

// File: tb/inbound_xlate_tb_top.sv
module inbound_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic        cfgIsOffset = 1'b0;
  logic [31:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic        outValid, outHit;
  logic [31:0] outAddr;

  int total = 0;
  int bad = 0;
  logic [31:0] mSize[4];
  logic [31:0] mOff [4];

  always #10 clk = ~clk;  // 50 MHz

  inbound_xlate dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgIsOffset(cfgIsOffset), .cfgData(cfgData), .inValid(inValid),
    .inAddr(inAddr), .outValid(outValid), .outHit(outHit), .outAddr(outAddr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // returns window index 0..3, or 4 on a miss (cumulative mod 2^32)
  function automatic int modelWin(logic [31:0] a);
    logic [31:0] edgeV = '0;
    for (int k = 0; k < 4; k++) begin
      edgeV = edgeV + mSize[k];
      if (a < edgeV) return k;
    end
    return 4;
  endfunction

  function automatic logic [31:0] modelAddr(logic [31:0] a);
    logic [31:0] baseV = '0;
    int w = modelWin(a);
    if (w == 4) return '0;
    for (int k = 0; k < w; k++) baseV = baseV + mSize[k];
    return a + mOff[w] - baseV;
  endfunction

  task automatic cfgWrite(int win, bit isOff, logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'(win); cfgIsOffset = isOff; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
    if (isOff) mOff[win] = val; else mSize[win] = val;
  endtask

  task automatic setCfg(logic [31:0] s0, s1, s2, s3, o0, o1, o2, o3);
    cfgWrite(0, 0, s0); cfgWrite(1, 0, s1); cfgWrite(2, 0, s2); cfgWrite(3, 0, s3);
    cfgWrite(0, 1, o0); cfgWrite(1, 1, o1); cfgWrite(2, 1, o2); cfgWrite(3, 1, o3);
  endtask

  // present one address (called at a negedge), check one cycle later
  task automatic send(logic [31:0] a, string tagOvr);
    int w = modelWin(a);
    string tag;
    case (w)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      default: tag = "R5";
    endcase
    if (tagOvr != "") tag = tagOvr;
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid R8"}, 32'(outValid), 32'd1);
    check({tag, " hit R6"}, 32'(outHit), 32'(w != 4));
    check({tag, " addr"}, outAddr, modelAddr(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mSize[k] = '0; mOff[k] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", 32'(outValid), 32'd0);
    check("R11 hit", 32'(outHit), 32'd0);
    check("R11 addr", outAddr, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    send(32'd0, "R11 miss");
    send(32'h1234_5678, "R11 miss");

    // layout A: includes an empty window (R6)
    setCfg(32'd3, 32'd5, 32'd0, 32'd7, 32'h1000, 32'h2000, 32'h3000, 32'h4000);
    for (int a = 0; a < 20; a++) send(32'(a), "");

    // layout B: offsets wrap past 2^32 (R7)
    setCfg(32'd4, 32'd4, 32'd4, 32'd4, 32'hFFFF_FFFE, 32'hFFFF_FFF0, 32'd1, 32'h8000_0000);
    for (int a = 0; a < 20; a++) send(32'(a), "");
    send(32'd2, "R7 wrap");

    // layout C: bounds wrap (R7), priority of low windows (R6)
    setCfg(32'd8, 32'd8, 32'd8, 32'hFFFF_FFF0, 32'h10, 32'h20, 32'h30, 32'h40);
    for (int a = 0; a < 32; a++) send(32'(a), "");
    for (int a = 0; a < 16; a++) send(32'hFFFF_FFF0 + 32'(a), "R7 top");

    // layout D: first window empty, address 0 goes to window 2 (R6)
    setCfg(32'd0, 32'd6, 32'd2, 32'd2, 32'h100, 32'h200, 32'h300, 32'h400);
    for (int a = 0; a < 12; a++) send(32'(a), "");

    // R8: no valid -> valid low next cycle; R9: outputs held
    @(negedge clk);
    check("R8 idle valid", 32'(outValid), 32'd0);
    check("R9 hold addr", outAddr, modelAddr(32'd11));
    check("R9 hold hit", 32'(outHit), 32'd0);

    // R10: write offset 2 in same cycle as an address; old value used
    send(32'd3, "R10 pre");
    cfgWe = 1'b1; cfgSel = 2'd1; cfgIsOffset = 1'b1; cfgData = 32'h9000;
    inValid = 1'b1; inAddr = 32'd3;
    @(negedge clk);
    cfgWe = 1'b0; inValid = 1'b0;
    check("R10 same-cycle old", outAddr, 32'h200 + 32'd3);
    // R10: registered result is not disturbed by the write
    @(negedge clk);
    check("R10 in-flight", outAddr, 32'h203);
    mOff[1] = 32'h9000;
    send(32'd3, "R10 new");
    // R10: size write (cfgIsOffset=0) to window 4 seen next
    cfgWrite(3, 0, 32'd20);
    send(32'd25, "R10 size");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule